// File: doc/BRIEF.md
# Peripheral Stop, Wake and Soft-Reset Controller

This block holds the control-register logic that sits between a host and the core of a serial-bus peripheral. It decides when the peripheral's core clock runs and when the baud prescaler runs. It sequences a self-clearing soft reset across several reset domains. It also qualifies register accesses by privilege level. The protocol engine, bit timing, message storage and interrupts live elsewhere. They only consume the clock enable, prescaler enable and domain reset outputs produced here.

The host writes an 8-bit control word and reads back the same word together with the read-only acknowledge bits. The layout is: bit 0 stop request, bit 1 freeze request, bit 2 self-wake enable, bit 3 auto-power-save enable, bit 4 supervisor-only, bit 5 soft reset (busy while 1), bit 6 freeze acknowledge, bit 7 stop acknowledge. The receive line uses 1 for recessive and 0 for dominant. It passes through a two-flop synchronizer, and the falling edge of the synchronized line is the wake event. The soft reset reaches only the sequencer, error, timer and host-register domains. The bus-timing configuration, the prescaler divider and the buffers have no reset output from this block, so they keep their contents.

Top module: `stop_wake_ctl`

## Requirements
- R1: A write with bit 5 set, accepted while idle, makes bit 5 read 1 and drives every `dom_rst` bit high from the next cycle on. In the same edge it clears bits 0 to 4, which includes the stop request.
- R2: The soft-reset window lasts exactly SRST_CYCLES (default 4) clock cycles. Bit 5 then reads 0 and `dom_rst` returns to all zeros without any host action.
- R3: Any write arriving while bit 5 reads 1 is ignored.
- R4: One cycle after bit 1 reads 1, `presc_en` is 0 and bit 6 is 1. After bit 1 clears, `presc_en` returns to 1 one cycle later. Bit 6 clears one cycle after that, so it never clears while the prescaler is still off.
- R5: One cycle after bit 0 reads 1, `clk_en` is 0 and bit 7 is 1. After bit 0 clears, `clk_en` returns to 1 one cycle later. Bit 7 clears one cycle after that.
- R6: While stopped with bit 2 set, a 1-to-0 change on `rx_in` clears bit 0 and raises `clk_en` on the third rising edge after the change. Bit 7 clears one cycle later, and bit 2 stays set.
- R7: While stopped with bit 2 clear, activity on `rx_in` leaves the block stopped.
- R8: A write that sets bit 2 in the same cycle a synchronized falling edge is detected leaves bit 2 clear and does not set bit 0, so the clock keeps running.
- R9: `acc_ok` is 1 when bit 4 is 0, whatever the privilege. When bit 4 is 1, `acc_ok` equals `priv_super`.
- R10: When bit 4 is 1, control writes made with `priv_super` = 0 are ignored.
- R11: With bit 3 set and not stopped, `clk_en` is 0 in the cycle after `task_pending` was 0, and 1 in the cycle after it was 1. With bit 3 clear, `task_pending` has no effect.
- R12: After reset the control word reads 0x00, `clk_en` and `presc_en` are 1, `dom_rst` is 0 and `acc_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 8 | Control word to write |
| priv_super | input | 1 | 1 = supervisor access, 0 = user access |
| rd_data | output | 8 | Control word with acknowledge and busy bits |
| acc_ok | output | 1 | Protected-register access permitted for the current privilege |
| rx_in | input | 1 | Raw receive line, 1 recessive, 0 dominant |
| task_pending | input | 1 | Core has work to do (auto power save) |
| clk_en | output | 1 | Clock enable for the peripheral core |
| presc_en | output | 1 | Baud prescaler enable |
| dom_rst | output | N_DOM | Soft-reset pulse per domain (sequencer, error, timer, host) |

## Verification
Control fields and the busy bit are due one edge after the write. The prescaler and clock enables change one edge after the request bit. The acknowledges clear one edge after their enable is back. The wake takes three edges from the `rx_in` fall, and the auto-power-save gate lags `task_pending` by one edge. The bench drives every input just after a falling clock edge and samples just before the next one. Each expected value is therefore read after exactly the number of rising edges the requirement names. The random phase keeps a one-cycle-delayed idle term in its model to match the registered gate.

// File: rtl/swc_pkg.sv
// Shared bit layout and field type for the stop/wake/soft-reset controller.
package swc_pkg;
    localparam int CTL_W     = 8;
    localparam int B_STOP    = 0;
    localparam int B_FRZ     = 1;
    localparam int B_WAKE    = 2;
    localparam int B_APS     = 3;
    localparam int B_SUP     = 4;
    localparam int B_SRST    = 5;
    localparam int B_FRZ_ACK = 6;
    localparam int B_STP_ACK = 7;

    typedef struct packed {
        logic sup;
        logic aps;
        logic wake;
        logic frz;
        logic stop;
    } ctl_fields_t;
endpackage

// File: rtl/swc_rx_edge.sv
// Receive-line synchronizer and falling-edge (recessive to dominant) detector.
// Assumes rx_in is asynchronous; idles high (recessive) out of reset.
module swc_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic fall_det
);
    logic [STAGES-1:0] sync_q;
    logic              rx_last_q;

    generate
        if (STAGES == 1) begin : g_one
            // single-stage capture of the line
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rx_in;
            end
        end else begin : g_chain
            // shift the line through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], rx_in};
            end
        end
    endgenerate

    assign rx_s = sync_q[STAGES-1];

    // remember last synchronized level; reference for the wake edge
    always_ff @(posedge clk) begin
        if (!rst_n) rx_last_q <= 1'b1;
        else        rx_last_q <= rx_s;
    end

    assign fall_det = rx_last_q & ~rx_s;

    // R6
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_det |=> !fall_det);
endmodule

// File: rtl/swc_gate_ack.sv
// Request/enable/acknowledge gate: drops en and raises ack on request;
// on release, re-raises en first and clears ack one cycle later.
// A wake pulse forces en back on at once (the request is cleared by the owner).
module swc_gate_ack (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic wake,
    output logic en,
    output logic ack
);
    // enable/acknowledge sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b1;
            ack <= 1'b0;
        end else if (wake) begin
            en  <= 1'b1;
        end else if (req && en) begin
            en  <= 1'b0;
            ack <= 1'b1;
        end else if (!req && !en) begin
            en  <= 1'b1;
        end else if (!req && en && ack) begin
            ack <= 1'b0;
        end
    end

    // R4, R5
    ack_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> (en && $past(en)));

    // R4, R5
    en_drop_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> $past(req));
endmodule

// File: rtl/swc_srst_seq.sv
// Soft-reset sequencer: a start pulse opens a window of CYCLES cycles,
// during which busy is high and each masked domain reset output is asserted.
module swc_srst_seq #(
    parameter int          CYCLES   = 4,
    parameter int          N_DOM    = 4,
    parameter logic [N_DOM-1:0] DOM_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [N_DOM-1:0] dom_rst
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            cnt_q <= LAST;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < N_DOM; i++) begin : g_dom
            if (DOM_MASK[i]) begin : g_on
                assign dom_rst[i] = busy;
            end else begin : g_off
                assign dom_rst[i] = 1'b0;
            end
        end
    endgenerate

    // R2
    busy_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
endmodule

// File: rtl/stop_wake_ctl.sv
// Top of the stop/wake/soft-reset controller. Holds the control fields,
// qualifies writes by privilege and soft-reset state, resolves the self-wake
// race, and drives core clock enable, prescaler enable and domain resets.
// Assumes a free-running clk; clk_en gates only the peripheral core.
module stop_wake_ctl
    import swc_pkg::*;
#(
    parameter int          SRST_CYCLES = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          N_DOM       = 4,
    parameter logic [N_DOM-1:0] DOM_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             priv_super,
    output logic [CTL_W-1:0] rd_data,
    output logic             acc_ok,
    input  logic             rx_in,
    input  logic             task_pending,
    output logic             clk_en,
    output logic             presc_en,
    output logic [N_DOM-1:0] dom_rst
);
    ctl_fields_t fld_q;
    logic rx_s, fall_det;
    logic busy, stop_en, stop_ack, frz_ack;
    logic wr_ok, srst_start, wake_hit, race_hit, aps_idle_q;

    swc_rx_edge #(.STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_s(rx_s), .fall_det(fall_det)
    );

    swc_srst_seq #(.CYCLES(SRST_CYCLES), .N_DOM(N_DOM), .DOM_MASK(DOM_MASK)) u_srst (
        .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(busy), .dom_rst(dom_rst)
    );

    swc_gate_ack u_stop_gate (
        .clk(clk), .rst_n(rst_n), .req(fld_q.stop), .wake(wake_hit),
        .en(stop_en), .ack(stop_ack)
    );

    swc_gate_ack u_frz_gate (
        .clk(clk), .rst_n(rst_n), .req(fld_q.frz), .wake(1'b0),
        .en(presc_en), .ack(frz_ack)
    );

    assign acc_ok     = !fld_q.sup || priv_super;
    assign wr_ok      = wr_en && !busy && acc_ok;
    assign srst_start = wr_ok && wr_data[B_SRST];
    assign race_hit   = wr_ok && wr_data[B_WAKE] && fall_det;
    assign wake_hit   = !stop_en && fld_q.wake && fall_det;

    // control field register: write, soft-reset clear, wake race and wake exit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else if (srst_start) begin
            fld_q <= '0;
        end else begin
            if (wr_ok) begin
                fld_q.frz <= wr_data[B_FRZ];
                fld_q.aps <= wr_data[B_APS];
                fld_q.sup <= wr_data[B_SUP];
                if (race_hit) begin
                    fld_q.wake <= 1'b0;
                    fld_q.stop <= 1'b0;
                end else begin
                    fld_q.wake <= wr_data[B_WAKE];
                    fld_q.stop <= wr_data[B_STOP];
                end
            end
            if (wake_hit) fld_q.stop <= 1'b0;
        end
    end

    // auto power save idle term, one cycle behind task_pending
    always_ff @(posedge clk) begin
        if (!rst_n) aps_idle_q <= 1'b0;
        else        aps_idle_q <= fld_q.aps && !task_pending;
    end

    assign clk_en = stop_en && !aps_idle_q;

    assign rd_data = {stop_ack, frz_ack, busy, fld_q.sup, fld_q.aps,
                      fld_q.wake, fld_q.frz, fld_q.stop};

    // R1
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (fld_q == '0));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fld_q));

    // R6
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_en && fld_q.wake && fall_det) |=> (!fld_q.stop && stop_en));

    // R8
    wake_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && acc_ok && !wr_data[B_SRST] && wr_data[B_WAKE] && fall_det)
        |=> (!fld_q.wake && !fld_q.stop));

    // R10
    user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld_q.sup && !priv_super && !busy) |=> $stable(fld_q));

    // R11
    aps_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q.aps && !task_pending) |=> !clk_en);
endmodule

// File: tb/stop_wake_ctl_bench.sv
// Self-checking bench: directed corner cases plus seeded random field writes.
module stop_wake_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       priv_super = 1'b1;
    logic [7:0] rd_data;
    logic       acc_ok;
    logic       rx_in = 1'b1;
    logic       task_pending = 1'b1;
    logic       clk_en, presc_en;
    logic [3:0] dom_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stop_wake_ctl u_stop_wake_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .priv_super(priv_super), .rd_data(rd_data), .acc_ok(acc_ok),
        .rx_in(rx_in), .task_pending(task_pending), .clk_en(clk_en),
        .presc_en(presc_en), .dom_rst(dom_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d, input logic sup = 1'b1);
        wr_en = 1'b1; wr_data = d; priv_super = sup;
        tick();
        wr_en = 1'b0; priv_super = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick();
    endtask

    function automatic logic exp_acc(input logic sup_bit, input logic priv);
        return !sup_bit || priv;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        // R12 reset state
        chk("R12 rd", rd_data, 8'h00);
        chk("R12 clk_en", clk_en, 1);
        chk("R12 presc", presc_en, 1);
        chk("R12 dom", dom_rst, 4'h0);
        chk("R12 acc", acc_ok, 1);

        // R1 / R2 / R3 soft reset
        wr(8'h0C);
        chk("R1 pre", rd_data, 8'h0C);
        wr(8'h20);
        chk("R1 busy", rd_data, 8'h20);
        chk("R1 dom", dom_rst, 4'hF);
        wr(8'h08);
        chk("R3 ignored", rd_data, 8'h20);
        tick(); chk("R2 busy3", rd_data, 8'h20);
        tick(); chk("R2 busy4", rd_data, 8'h20);
        tick(); chk("R2 done", rd_data, 8'h00);
        chk("R2 dom", dom_rst, 4'h0);
        // R1 soft reset clears stop
        wr(8'h01); tick();
        chk("R5 stopped", clk_en, 0);
        wr(8'h20);
        chk("R1 stop clr", rd_data, 8'hA0);
        tick(); chk("R1 clk back", clk_en, 1);
        tick(); chk("R1 ack clr", rd_data, 8'h20);
        tick(2); chk("R2 end", rd_data, 8'h00);

        // R4 freeze
        wr(8'h02);
        chk("R4 req", rd_data, 8'h02); chk("R4 presc on", presc_en, 1);
        tick();
        chk("R4 presc off", presc_en, 0); chk("R4 ack", rd_data, 8'h42);
        wr(8'h00);
        chk("R4 still off", presc_en, 0); chk("R4 ack hold", rd_data, 8'h40);
        tick();
        chk("R4 presc back", presc_en, 1); chk("R4 ack after", rd_data, 8'h40);
        tick(); chk("R4 ack clr", rd_data, 8'h00);

        // R5 stop
        wr(8'h01);
        chk("R5 req", clk_en, 1);
        tick();
        chk("R5 clk off", clk_en, 0); chk("R5 ack", rd_data, 8'h81);
        wr(8'h00);
        chk("R5 still off", clk_en, 0);
        tick();
        chk("R5 clk back", clk_en, 1); chk("R5 ack hold", rd_data, 8'h80);
        tick(); chk("R5 ack clr", rd_data, 8'h00);

        // R7 no self-wake
        wr(8'h01); tick();
        rx_in = 1'b0; tick(5);
        chk("R7 stays", clk_en, 0); chk("R7 rd", rd_data, 8'h81);
        rx_in = 1'b1; tick(3);
        wr(8'h00); tick(2);
        chk("R7 exit", rd_data, 8'h00);

        // R6 self-wake
        wr(8'h05); tick();
        chk("R6 stopped", rd_data, 8'h85);
        rx_in = 1'b0; tick(2);
        chk("R6 not yet", clk_en, 0);
        tick();
        chk("R6 clk", clk_en, 1); chk("R6 rd", rd_data, 8'h84);
        tick(); chk("R6 ack clr", rd_data, 8'h04);
        rx_in = 1'b1; tick(3);
        wr(8'h00);

        // R8 race
        rx_in = 1'b0; tick(2);
        wr(8'h05);
        chk("R8 bits", rd_data, 8'h00);
        tick(); chk("R8 clk", clk_en, 1); chk("R8 rd", rd_data, 8'h00);
        rx_in = 1'b1; tick(3);

        // R9 / R10 supervisor
        wr(8'h10);
        chk("R10 set", rd_data, 8'h10);
        priv_super = 1'b0; #1; chk("R9 user", acc_ok, 0);
        priv_super = 1'b1; #1; chk("R9 super", acc_ok, 1);
        tick();
        wr(8'h18, 1'b0);
        chk("R10 blocked", rd_data, 8'h10);
        wr(8'h00);
        priv_super = 1'b0; #1; chk("R9 open", acc_ok, 1);
        tick();
        wr(8'h08, 1'b0);
        chk("R10 user ok", rd_data, 8'h08);

        // R11 auto power save
        task_pending = 1'b0;
        chk("R11 lag", clk_en, 1);
        tick(); chk("R11 off", clk_en, 0);
        task_pending = 1'b1; tick(); chk("R11 work", clk_en, 1);
        task_pending = 1'b0; tick(); chk("R11 idle", clk_en, 0);
        wr(8'h00); chk("R11 lag2", clk_en, 0);
        tick(); chk("R11 disabled", clk_en, 1);

        // random phase: fields 2..4, privilege, task_pending
        do_reset();
        begin
            logic [2:0] f_m;
            logic       idle_m;
            void'($urandom(32'h5EED));
            f_m = '0;
            for (int it = 0; it < 400; it++) begin
                logic       doit, priv, tp;
                logic [7:0] d;
                doit = $urandom_range(0, 1);
                priv = $urandom_range(0, 1);
                tp   = $urandom_range(0, 1);
                d    = {3'b000, 3'($urandom_range(0, 7)), 2'b00};
                wr_en = doit; wr_data = d; priv_super = priv; task_pending = tp;
                #1;
                chk("R9 rand", acc_ok, exp_acc(f_m[2], priv));
                idle_m = f_m[1] && !tp;
                if (doit && exp_acc(f_m[2], priv)) f_m = d[4:2];
                tick();
                wr_en = 1'b0;
                chk("R10 rand", rd_data, {3'b000, f_m, 2'b00});
                chk("R11 rand", clk_en, !idle_m);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule